// File: doc/BRIEF.md
# PCI Target Burst Address Tracker

This block is the address unit on the target side of a PCI interface, used when another bus master reads or writes local DRAM. In the clock where FRAME is first seen asserted, it samples the multiplexed AD lines. Address bits 31 to 10 and the two byte-lane bits 1 and 0 then stay fixed for the whole transaction. The word index, bits 9 to 2, sits in a loadable counter. The counter steps by one on every clock in which a data phase completes, so the DRAM address follows a linear burst without further help from the master.

A 1 KB block holds 256 words. The counter cannot carry into bit 10, so a burst that runs on would wrap back to the start of the same block. To prevent this, the block raises a boundary flag as soon as the word index reaches the last word of the block, one data phase before any crossing. The target control logic uses the flag to assert STOP and disconnect the master. The flag stays set until the next address phase. DRAM timing is handled elsewhere.

Top module: `pci_tgt_burst_addr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dram_addr` is cleared to 0 and `bound_flag` to 0 after that edge.
- R2: On a rising edge where `frame_n` is 0 and `frame_n` was 1 at the previous edge (or at the first edge after reset), `dram_addr` takes the value of `ad_in` after that edge.
- R3: While `frame_n` stays 0 on later edges, changes on `ad_in` have no effect on `dram_addr`.
- R4: Except at an address capture, bits 31..10 and bits 1..0 of `dram_addr` never change. This holds even when the word index wraps.
- R5: On an edge without a capture where `irdy_n` and `trdy_n` are both 0, bits 9..2 of `dram_addr` increase by one, modulo 256.
- R6: On an edge without a capture where `irdy_n` or `trdy_n` is 1, bits 9..2 of `dram_addr` hold their value.
- R7: `bound_flag` is 1 after any edge at which the word index (bits 9..2) becomes 255. This covers both a capture of an address whose bits 9..2 are all ones and a step from 254.
- R8: Once set, `bound_flag` stays 1 through later steps, including the wrap to 0, until the next capture. A capture whose bits 9..2 are not all ones clears it.
- R9: A data phase that completes after `frame_n` has returned to 1 (the final phase) still advances the word index.
- R10: After `frame_n` has been 1 for at least one edge, a new assertion captures a fresh address. This restarts both the counter and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_in | input | 32 | Multiplexed address/data lines as seen by the target |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| dram_addr | output | 32 | Current DRAM byte address |
| bound_flag | output | 1 | Word index has reached the last word of the 1 KB block; request STOP |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 1 KB block and 4-byte words, which gives an 8-bit word counter. This counter is small enough that directed bursts starting at indices 250 and 255 reach the flag, the wrap from 255 to 0 and the sticky behaviour within a few dozen cycles. Random traffic biases start indices toward the top of the block so that boundary hits recur. The same random traffic also mixes wait states, final phases after FRAME release and back-to-back frames.

// File: rtl/pci_tba_pkg.sv
package pci_tba_pkg;

    // Default geometry: 32-bit address, 1 KB block, 4-byte words.
    localparam int unsigned TBA_ADDR_W    = 32;
    localparam int unsigned TBA_BLOCK_LOG = 10;
    localparam int unsigned TBA_LANE_BITS = 2;

    // Per-edge control decoded from the bus handshake.
    typedef struct packed {
        logic load;   // first clock of FRAME: capture AD
        logic step;   // completed data phase: advance word index
    } tba_ctl_t;

    typedef enum logic [1:0] {
        TBA_IDLE = 2'd0,
        TBA_LOAD = 2'd1,
        TBA_STEP = 2'd2
    } tba_act_e;

    function automatic tba_act_e tba_decode(input tba_ctl_t c);
        if (c.load)      return TBA_LOAD;
        else if (c.step) return TBA_STEP;
        else             return TBA_IDLE;
    endfunction

endpackage

// File: rtl/tba_phase_ctl.sv
module tba_phase_ctl
    import pci_tba_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_n,
    input  logic     irdy_n,
    input  logic     trdy_n,
    output tba_ctl_t ctl
);

    logic frame_seen_q;   // FRAME was asserted at the previous edge

    always_ff @(posedge clk) begin
        if (rst) frame_seen_q <= 1'b0;
        else     frame_seen_q <= ~frame_n;
    end

    always_comb begin
        ctl.load = ~frame_n & ~frame_seen_q;
        ctl.step = ~ctl.load & ~irdy_n & ~trdy_n;
    end

    // A capture can never follow a capture while FRAME stays asserted.
    assert_single_capture_R3: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> !ctl.load);

    // A capture edge is never also counted as a data phase.
    assert_load_not_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.load |-> !ctl.step);

endmodule

// File: rtl/tba_hold_reg.sv
module tba_hold_reg #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BLOCK_LOG = 10,
    parameter int unsigned LANE_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       ad_in,
    output logic [ADDR_W-1:BLOCK_LOG] hi_q,
    output logic [LANE_BITS-1:0]    lane_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lane_q <= '0;
        end else if (load) begin
            hi_q   <= ad_in[ADDR_W-1:BLOCK_LOG];
            lane_q <= ad_in[LANE_BITS-1:0];
        end
    end

endmodule

// File: rtl/tba_word_ctr.sv
module tba_word_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] idx_q,
    output logic             flag_q
);

    localparam logic [CNT_W-1:0] IDX_LAST = '1;

    logic [CNT_W:0]   sum;       // carry plus incremented index
    logic [CNT_W-1:0] idx_next;
    logic             flag_next;

    always_comb begin
        sum       = {1'b0, idx_q} + {{CNT_W{1'b0}}, 1'b1};
        idx_next  = idx_q;
        flag_next = flag_q;
        if (load) begin
            idx_next  = load_val;
            flag_next = (load_val == IDX_LAST);
        end else if (step) begin
            idx_next  = sum[CNT_W-1:0];
            // set on reaching the last word; the carry keeps it set on a wrap
            flag_next = flag_q | (sum[CNT_W-1:0] == IDX_LAST) | sum[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            idx_q  <= idx_next;
            flag_q <= flag_next;
        end
    end

    assert_step_inc_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (idx_q == CNT_W'($past(idx_q) + 1'b1)));

    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(idx_q));

    assert_flag_early_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !load && idx_q == IDX_LAST - 1'b1) |=> flag_q);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !load) |=> flag_q);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != IDX_LAST) |=> !flag_q);

endmodule

// File: rtl/pci_tgt_burst_addr.sv
module pci_tgt_burst_addr
    import pci_tba_pkg::*;
#(
    parameter int unsigned ADDR_W    = TBA_ADDR_W,
    parameter int unsigned BLOCK_LOG = TBA_BLOCK_LOG,
    parameter int unsigned LANE_BITS = TBA_LANE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ad_in,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              bound_flag
);

    localparam int unsigned CNT_W = BLOCK_LOG - LANE_BITS;

    tba_ctl_t                 ctl;
    tba_act_e                 act;
    logic [ADDR_W-1:BLOCK_LOG] hi_q;
    logic [LANE_BITS-1:0]     lane_q;
    logic [CNT_W-1:0]         idx_q;

    assign act = tba_decode(ctl);

    tba_phase_ctl u_phase (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .trdy_n  (trdy_n),
        .ctl     (ctl)
    );

    tba_hold_reg #(
        .ADDR_W    (ADDR_W),
        .BLOCK_LOG (BLOCK_LOG),
        .LANE_BITS (LANE_BITS)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (act == TBA_LOAD),
        .ad_in  (ad_in),
        .hi_q   (hi_q),
        .lane_q (lane_q)
    );

    tba_word_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (act == TBA_LOAD),
        .step     (act == TBA_STEP),
        .load_val (ad_in[BLOCK_LOG-1:LANE_BITS]),
        .idx_q    (idx_q),
        .flag_q   (bound_flag)
    );

    assign dram_addr = {hi_q, idx_q, lane_q};

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (act == TBA_LOAD) |=> (dram_addr == $past(ad_in)));

    assert_hi_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (act != TBA_LOAD) |=> ($stable(dram_addr[ADDR_W-1:BLOCK_LOG]) &&
                               $stable(dram_addr[LANE_BITS-1:0])));

endmodule

// File: tb/test_pci_tgt_burst_addr.sv
module test_pci_tgt_burst_addr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad_in = '0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic [31:0] dram_addr;
    logic        bound_flag;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          finished = 1'b0;

    // bench-side model state
    logic [31:0] m_addr = '0;
    logic        m_flag = 1'b0;
    logic        m_frame_seen = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pci_tgt_burst_addr i_pci_tgt_burst_addr (
        .clk        (clk),
        .rst        (rst),
        .ad_in      (ad_in),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n),
        .dram_addr  (dram_addr),
        .bound_flag (bound_flag)
    );

    function automatic logic [7:0] widx(input logic [31:0] a);
        return a[9:2];
    endfunction

    function automatic logic [31:0] with_idx(input logic [31:0] a, input logic [7:0] i);
        return {a[31:10], i, a[1:0]};
    endfunction

    // Expected next state, derived from the requirements.
    task automatic model_edge();
        logic first;
        logic [7:0] ni;
        if (rst) begin
            m_addr = '0; m_flag = 1'b0; m_frame_seen = 1'b0;
        end else begin
            first = !frame_n && !m_frame_seen;
            if (first) begin
                m_addr = ad_in;
                m_flag = (widx(ad_in) == 8'hFF);
            end else if (!irdy_n && !trdy_n) begin
                ni = widx(m_addr) + 8'd1;
                m_addr = with_idx(m_addr, ni);
                m_flag = m_flag | (ni == 8'hFF);
            end
            m_frame_seen = !frame_n;
        end
    endtask

    task automatic check(input string tag, input string ftag);
        n_tests++;
        if (dram_addr !== m_addr) begin
            n_fail++;
            $display("FAIL %s dram_addr got %h expected %h", tag, dram_addr, m_addr);
        end
        n_tests++;
        if (bound_flag !== m_flag) begin
            n_fail++;
            $display("FAIL %s bound_flag got %b expected %b", ftag, bound_flag, m_flag);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
    task automatic step(input logic f, input logic i, input logic t,
                        input logic [31:0] a, input string tag, input string ftag);
        frame_n = f; irdy_n = i; trdy_n = t; ad_in = a;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, ftag);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd20240607));
        @(negedge clk);
        rst = 1'b1;
        step(1, 1, 1, 32'hFFFF_FFFF, "R1", "R1");
        step(0, 0, 0, 32'h1234_5678, "R1", "R1");
        rst = 1'b0;

        // R2: capture, then R3: later AD changes ignored while FRAME held
        step(0, 1, 1, 32'hA5A5_0C03, "R2", "R8");
        step(0, 1, 1, 32'h5A5A_F3FC, "R3", "R3");
        step(0, 1, 0, 32'h0000_0000, "R6", "R8");
        step(0, 0, 1, 32'hFFFF_FFFF, "R6", "R8");
        step(0, 0, 0, 32'h1111_1111, "R5", "R8");

        // Burst from index 250 across the block end: flag early, sticky, wrap
        step(1, 1, 1, 32'h0, "R10", "R8");
        a = with_idx(32'hCAFE_0002, 8'd250);
        step(0, 1, 1, a, "R10", "R8");
        for (int k = 0; k < 4; k++) step(0, 0, 0, $urandom, "R5", "R7");
        step(0, 0, 1, 32'h0, "R6", "R7");
        step(0, 0, 0, 32'h0, "R5", "R7");   // index 255 reached
        step(0, 1, 1, 32'h0, "R6", "R7");
        step(0, 0, 0, 32'h0, "R4", "R8");   // wrap to 0, upper bits unchanged
        step(0, 0, 0, 32'h0, "R4", "R8");
        step(1, 0, 0, 32'h0, "R9", "R8");   // final phase after FRAME release
        step(1, 1, 1, 32'h0, "R6", "R8");

        // Capture at the last word sets the flag; a later capture clears it
        step(0, 1, 1, with_idx(32'h8000_0001, 8'hFF), "R2", "R7");
        step(1, 0, 0, 32'h0, "R9", "R8");
        step(0, 1, 1, with_idx(32'h0000_1000, 8'h10), "R10", "R8");
        step(1, 1, 1, 32'h0, "R6", "R8");

        // Random traffic, start indices biased toward the top of the block
        for (int n = 0; n < 4000; n++) begin
            logic f, i, t;
            f = ($urandom_range(0, 15) == 0) ? ~frame_n : frame_n;
            i = ($urandom_range(0, 3) == 0);
            t = ($urandom_range(0, 3) == 0);
            a = $urandom;
            if ($urandom_range(0, 1) == 1) a[9:2] = 8'hF0 | 8'($urandom_range(0, 15));
            step(f, i, t, a, (f == 1'b0) ? "R2" : "R5", "R7");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule